// File: doc/BRIEF.md
# Three-Level Page Table Walker

This block translates a 32-bit virtual address into a 36-bit physical address. It walks page tables held in memory. A walk starts from a context-table base register and a 16-bit current context number. It reads the context entry first, then up to three further table levels, one 32-bit descriptor per read. Every descriptor carries a 2-bit type code. That code says whether the walk goes on to another table, ends with a translation, or stops with a fault. A translation entry may sit at level 1, 2 or 3, so one entry maps a 16 MB region, a 256 KB region or a 4 KB page.

A client presents an address on a valid/ready lookup port. The walker drops ready for the whole walk. It issues word reads one at a time on a simple request/response memory port. When the walk ends it pulses a result carrying the final descriptor, the level at which the walk stopped, a fault flag and the physical address. Two write strobes load the table base register and the context register.

Top module: `tbl_walker`

## Requirements
- R1: The type code sits in descriptor bits [1:0]. 0 is invalid, 1 points to a further table, 2 is a translation entry and 3 is reserved.
- R2: The base register stores the written word with bits [3:0] cleared. The context entry is read at byte address (base register << 4) + context × 4, using the 16-bit context register.
- R3: A pointer descriptor gives the next table at ({desc[31:4], 8'b0}) + index × 4. The index is VA[31:24] at level 1, VA[23:18] at level 2 and VA[17:12] at level 3.
- R4: A translation entry found at level 1 gives the physical address {entry[31:20], VA[23:0]}, with result level 1.
- R5: A translation entry found at level 2 gives {entry[31:14], VA[17:0]}, with result level 2.
- R6: A translation entry found at level 3 gives {entry[31:8], VA[11:0]}, with result level 3.
- R7: An invalid or reserved descriptor at any level ends the walk at once. The result has the fault flag set, the level where the walk stopped, the offending descriptor and a zero address. No further read is issued.
- R8: A translation entry in the context entry is a fault at level 0. A pointer descriptor at level 3 is a fault at level 3.
- R9: At most one memory read is outstanding. The request valid is a one-cycle pulse, and the next read is issued only after the previous response.
- R10: Lookup ready is high only while idle. It is low from acceptance up to and including the single cycle in which the result valid is high.
- R11: The result descriptor is returned unchanged, with all of its attribute bits [7:2] intact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| lookupValid | input | 1 | Lookup request present |
| lookupVa | input | 32 | Virtual address to translate |
| lookupReady | output | 1 | Walker idle and accepting |
| respValid | output | 1 | One-cycle result strobe |
| respEntry | output | 32 | Last descriptor read |
| respLevel | output | 2 | Level where the walk stopped (0 = context entry) |
| respFault | output | 1 | Walk ended in a fault |
| respPa | output | 36 | Translated physical address, zero on fault |
| memReqValid | output | 1 | Word read request pulse |
| memReqAddr | output | 36 | Byte address of the read |
| memRespValid | input | 1 | Read data valid |
| memRespData | input | 32 | Read data |
| basePtrWe | input | 1 | Write strobe for the table base register |
| basePtrData | input | 32 | Value for the table base register |
| ctxWe | input | 1 | Write strobe for the context register |
| ctxData | input | 16 | Value for the context register |

## Verification
The bench goes after walks that end at each of the four levels. It feeds an invalid or a reserved code at different depths, a translation entry placed in the context entry, and a pointer at the last level. A walker that treated code 3 as a leaf, or a context-level leaf as a success, would report no fault. One that kept walking after a fault would issue an extra read, which the memory model counts. The base register is written with its low bits set and a high context number is used, so a missing mask or a wrong scale moves the context read to an address with nothing stored there. Each leaf level checks its own offset split, which exposes an address built with the wrong level's bit boundary.

// File: rtl/walk_pkg.sv
package walk_pkg;
  localparam int DESC_W = 32;
  localparam int PA_W   = 36;
  localparam int VA_W   = 32;

  localparam logic [1:0] ET_INVALID = 2'd0;
  localparam logic [1:0] ET_PTR     = 2'd1;
  localparam logic [1:0] ET_LEAF    = 2'd2;
  localparam logic [1:0] ET_RSVD    = 2'd3;

  typedef enum logic [2:0] {
    ST_IDLE, ST_FETCH_CTX, ST_FETCH_L1, ST_FETCH_L2, ST_FETCH_L3, ST_DONE
  } walkState_t;

  typedef struct packed {
    logic       issueCtx;
    logic       issueNext;
    logic       finish;
    logic       fault;
    logic [1:0] lvl;
  } walkStrobe_t;
endpackage

// File: rtl/walk_ctrl.sv
module walk_ctrl
  import walk_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        lookupValid,
  input  logic        memRespValid,
  input  logic [1:0]  respType,
  output logic        lookupReady,
  output walkStrobe_t strobe
);
  walkState_t state, nxt;
  logic       fetching;
  logic [1:0] curLvl;

  always_comb begin
    fetching = 1'b1;
    curLvl   = 2'd0;
    case (state)
      ST_FETCH_CTX: curLvl = 2'd0;
      ST_FETCH_L1:  curLvl = 2'd1;
      ST_FETCH_L2:  curLvl = 2'd2;
      ST_FETCH_L3:  curLvl = 2'd3;
      default:      fetching = 1'b0;
    endcase
  end

  always_comb begin
    nxt    = state;
    strobe = '0;
    strobe.lvl = curLvl;
    if (state == ST_IDLE) begin
      if (lookupValid) begin
        strobe.issueCtx = 1'b1;
        nxt = ST_FETCH_CTX;
      end
    end else if (state == ST_DONE) begin
      nxt = ST_IDLE;
    end else if (fetching && memRespValid) begin
      if (respType == ET_PTR && curLvl != 2'd3) begin
        strobe.issueNext = 1'b1;
        case (curLvl)
          2'd0:    nxt = ST_FETCH_L1;
          2'd1:    nxt = ST_FETCH_L2;
          default: nxt = ST_FETCH_L3;
        endcase
      end else begin
        strobe.finish = 1'b1;
        strobe.fault  = !(respType == ET_LEAF && curLvl != 2'd0);
        nxt = ST_DONE;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nxt;
  end

  assign lookupReady = (state == ST_IDLE);

  // R7: an invalid code ends the walk on the next cycle
  a_r7_invalid_stops: assert property (@(posedge clk) disable iff (!rstN)
    (fetching && memRespValid && respType == ET_INVALID) |=> state == ST_DONE);
  // R8: nothing follows a level-3 descriptor
  a_r8_l3_terminal: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_FETCH_L3 && memRespValid) |=> state == ST_DONE);
endmodule

// File: rtl/walk_dpath.sv
module walk_dpath
  import walk_pkg::*;
#(
  parameter int CTX_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  walkStrobe_t       strobe,
  input  logic [VA_W-1:0]   lookupVa,
  input  logic              memRespValid,
  input  logic [DESC_W-1:0] memRespData,
  input  logic              basePtrWe,
  input  logic [DESC_W-1:0] basePtrData,
  input  logic              ctxWe,
  input  logic [CTX_W-1:0]  ctxData,
  output logic              memReqValid,
  output logic [PA_W-1:0]   memReqAddr,
  output logic              respValid,
  output logic [DESC_W-1:0] respEntry,
  output logic [1:0]        respLevel,
  output logic              respFault,
  output logic [PA_W-1:0]   respPa
);
  localparam int IDX_W = 8;

  logic [DESC_W-1:0] basePtr;
  logic [CTX_W-1:0]  ctxNum;
  logic [VA_W-1:0]   vaReg;
  logic [IDX_W-1:0]  nextIdx;
  logic [PA_W-1:0]   ctxAddr, nextAddr, leafPa;
  logic              pending;

  always_comb begin
    case (strobe.lvl)
      2'd0:    nextIdx = vaReg[31:24];
      2'd1:    nextIdx = {2'b0, vaReg[23:18]};
      default: nextIdx = {2'b0, vaReg[17:12]};
    endcase
  end

  assign ctxAddr  = {basePtr, 4'b0} + PA_W'({ctxNum, 2'b00});
  assign nextAddr = {memRespData[31:4], 8'b0} + PA_W'({nextIdx, 2'b00});

  always_comb begin
    case (strobe.lvl)
      2'd1:    leafPa = {memRespData[31:20], vaReg[23:0]};
      2'd2:    leafPa = {memRespData[31:14], vaReg[17:0]};
      default: leafPa = {memRespData[31:8],  vaReg[11:0]};
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      basePtr <= '0;
      ctxNum  <= '0;
    end else begin
      if (basePtrWe) basePtr <= {basePtrData[31:4], 4'b0};
      if (ctxWe)     ctxNum  <= ctxData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      vaReg       <= '0;
      memReqValid <= 1'b0;
      memReqAddr  <= '0;
      respValid   <= 1'b0;
      respEntry   <= '0;
      respLevel   <= '0;
      respFault   <= 1'b0;
      respPa      <= '0;
      pending     <= 1'b0;
    end else begin
      memReqValid <= strobe.issueCtx | strobe.issueNext;
      respValid   <= strobe.finish;
      if (strobe.issueCtx) begin
        vaReg      <= lookupVa;
        memReqAddr <= ctxAddr;
      end else if (strobe.issueNext) begin
        memReqAddr <= nextAddr;
      end
      if (strobe.finish) begin
        respEntry <= memRespData;
        respLevel <= strobe.lvl;
        respFault <= strobe.fault;
        respPa    <= strobe.fault ? '0 : leafPa;
      end
      if (memReqValid)       pending <= 1'b1;
      else if (memRespValid) pending <= 1'b0;
    end
  end

  // R9: request is a single-cycle pulse
  a_r9_req_pulse: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid |=> !memReqValid);
  // R9: no new request while one is in flight
  a_r9_one_outstanding: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid |-> !pending);
  // R1, R8: a success always carries a leaf code below the context level
  a_r1_ok_is_leaf: assert property (@(posedge clk) disable iff (!rstN)
    (respValid && !respFault) |-> (respEntry[1:0] == ET_LEAF && respLevel != 2'd0));
  // R7: faults report a zero address
  a_r7_fault_pa_zero: assert property (@(posedge clk) disable iff (!rstN)
    (respValid && respFault) |-> respPa == '0);
  // R6: a 4 KB page keeps the low twelve address bits
  a_r6_page_offset: assert property (@(posedge clk) disable iff (!rstN)
    (respValid && !respFault && respLevel == 2'd3) |-> respPa[11:0] == vaReg[11:0]);
endmodule

// File: rtl/tbl_walker.sv
module tbl_walker
  import walk_pkg::*;
#(
  parameter int CTX_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              lookupValid,
  input  logic [31:0]       lookupVa,
  output logic              lookupReady,
  output logic              respValid,
  output logic [31:0]       respEntry,
  output logic [1:0]        respLevel,
  output logic              respFault,
  output logic [35:0]       respPa,
  output logic              memReqValid,
  output logic [35:0]       memReqAddr,
  input  logic              memRespValid,
  input  logic [31:0]       memRespData,
  input  logic              basePtrWe,
  input  logic [31:0]       basePtrData,
  input  logic              ctxWe,
  input  logic [CTX_W-1:0]  ctxData
);
  walkStrobe_t strobe;

  walk_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .lookupValid(lookupValid),
    .memRespValid(memRespValid), .respType(memRespData[1:0]),
    .lookupReady(lookupReady), .strobe(strobe)
  );

  walk_dpath #(.CTX_W(CTX_W)) uDpath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .lookupVa(lookupVa),
    .memRespValid(memRespValid), .memRespData(memRespData),
    .basePtrWe(basePtrWe), .basePtrData(basePtrData),
    .ctxWe(ctxWe), .ctxData(ctxData),
    .memReqValid(memReqValid), .memReqAddr(memReqAddr),
    .respValid(respValid), .respEntry(respEntry), .respLevel(respLevel),
    .respFault(respFault), .respPa(respPa)
  );

  // R10: the result never appears while the walker claims to be idle
  a_r10_busy_at_result: assert property (@(posedge clk) disable iff (!rstN)
    respValid |-> !lookupReady);
endmodule

// File: tb/tb_tbl_walker.sv
module tb_tbl_walker;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rstN, lookupValid, lookupReady, respValid, respFault;
  logic [31:0] lookupVa, respEntry, memRespData, basePtrData;
  logic [1:0]  respLevel;
  logic [35:0] respPa, memReqAddr;
  logic        memReqValid, memRespValid, basePtrWe, ctxWe;
  logic [15:0] ctxData;

  tbl_walker dut (.*);

  typedef struct {
    logic [31:0] entry;
    logic [1:0]  level;
    logic        fault;
    logic [35:0] pa;
    int          reads;
    string       tag;
  } expItem_t;

  expItem_t    expQ[$];
  logic [31:0] mem[logic [35:0]];
  int checks = 0, errors = 0;
  int memLat = 1, timer = 0, readCount = 0;
  logic [35:0] pendAddr;
  logic [31:0] expBase;
  logic [15:0] expCtx;

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // memory model and result monitor share one sampling point
  always @(negedge clk) begin
    memRespValid = 1'b0;
    if (timer > 0) begin
      timer--;
      if (timer == 0) begin
        memRespValid = 1'b1;
        memRespData  = mem.exists(pendAddr) ? mem[pendAddr] : 32'h0;
      end
    end
    if (rstN && memReqValid) begin
      check(timer == 0, "R9", "read while outstanding", 64'(timer), 64'd0);
      readCount++;
      pendAddr = memReqAddr;
      timer    = memLat;
    end
    if (rstN && respValid) begin
      expItem_t e;
      check(!lookupReady, "R10", "ready during result", 64'(lookupReady), 64'd0);
      if (expQ.size() == 0) check(1'b0, "R10", "unexpected result", 64'd1, 64'd0);
      else begin
        e = expQ.pop_front();
        check(respEntry == e.entry, e.tag, "entry", 64'(respEntry), 64'(e.entry));
        check(respLevel == e.level, e.tag, "level", 64'(respLevel), 64'(e.level));
        check(respFault == e.fault, e.tag, "fault", 64'(respFault), 64'(e.fault));
        check(respPa == e.pa, e.tag, "pa", 64'(respPa), 64'(e.pa));
        check(readCount == e.reads, e.tag, "reads", 64'(readCount), 64'(e.reads));
      end
      readCount = 0;
    end
  end

  task automatic writeBase(input logic [31:0] v);
    @(negedge clk); basePtrWe = 1'b1; basePtrData = v;
    @(negedge clk); basePtrWe = 1'b0;
    expBase = {v[31:4], 4'b0};  // R2 masking
  endtask

  task automatic writeCtx(input logic [15:0] v);
    @(negedge clk); ctxWe = 1'b1; ctxData = v;
    @(negedge clk); ctxWe = 1'b0;
    expCtx = v;
  endtask

  // installs descriptors along the walk path and queues the expected result
  task automatic runCase(input logic [31:0] va, input logic [31:0] d0,
                         input logic [31:0] d1, input logic [31:0] d2,
                         input logic [31:0] d3, input string tag);
    logic [31:0] d[4];
    logic [31:0] desc;
    logic [35:0] addr;
    logic [7:0]  idx;
    expItem_t    e;
    int          lvl;
    d[0] = d0; d[1] = d1; d[2] = d2; d[3] = d3;
    while (!lookupReady) @(negedge clk);
    addr = {expBase, 4'b0} + 36'({expCtx, 2'b00});   // R2
    mem[addr] = d[0];
    desc = d[0]; lvl = 0; e.reads = 1;
    while (desc[1:0] == 2'd1 && lvl < 3) begin        // R3
      idx  = (lvl == 0) ? va[31:24] : (lvl == 1) ? {2'b0, va[23:18]} : {2'b0, va[17:12]};
      addr = {desc[31:4], 8'b0} + 36'({idx, 2'b00});
      lvl++;
      mem[addr] = d[lvl];
      desc = d[lvl];
      e.reads++;
    end
    e.entry = desc;
    e.level = 2'(lvl);
    e.fault = !(desc[1:0] == 2'd2 && lvl != 0);
    case (lvl)
      1:       e.pa = {desc[31:20], va[23:0]};
      2:       e.pa = {desc[31:14], va[17:0]};
      default: e.pa = {desc[31:8],  va[11:0]};
    endcase
    if (e.fault) e.pa = '0;
    e.tag = tag;
    expQ.push_back(e);
    lookupValid = 1'b1; lookupVa = va;
    @(negedge clk);
    lookupValid = 1'b0;
    check(!lookupReady, "R10", "ready after accept", 64'(lookupReady), 64'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog R10 actual hung expected finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rstN = 1'b0; lookupValid = 1'b0; lookupVa = '0; basePtrWe = 1'b0;
    basePtrData = '0; ctxWe = 1'b0; ctxData = '0; memRespData = '0;
    memRespValid = 1'b0; expBase = '0; expCtx = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(lookupReady == 1'b1, "R10", "reset ready", 64'(lookupReady), 64'd1);
    check(respValid == 1'b0, "R10", "reset resp", 64'(respValid), 64'd0);
    check(memReqValid == 1'b0, "R9", "reset req", 64'(memReqValid), 64'd0);

    writeBase(32'h0000_123F);   // R2 low bits must be dropped
    writeCtx(16'd5);
    runCase(32'h1234_5678, 32'h0000_2001, 32'hABCD_E0AE, 0, 0, "R4");
    memLat = 2;
    runCase(32'h8765_4321, 32'h0000_3001, 32'h0000_4101, 32'h1234_5AE2, 0, "R5");
    runCase(32'hCAFE_BABE, 32'h0000_5001, 32'h0000_6001, 32'h0000_7001,
            32'hFEDC_BA9E, "R6");
    memLat = 1;
    runCase(32'h0100_0000, 32'h0000_8001, 32'h0000_1230, 0, 0, "R7");
    runCase(32'h0240_0000, 32'h0000_9001, 32'h0000_A001, 32'h0000_5553, 0, "R7");
    runCase(32'h0300_0000, 32'h0000_0000, 0, 0, 0, "R7");
    runCase(32'h0400_0000, 32'h1111_1102, 0, 0, 0, "R8");
    memLat = 3;
    runCase(32'h0512_3000, 32'h0000_B001, 32'h0000_C001, 32'h0000_D001,
            32'h0000_E001, "R8");
    writeCtx(16'hFFFF);         // R2 top context
    runCase(32'h7700_0ABC, 32'h0000_F001, 32'h5A5A_5F22, 0, 0, "R2");
    memLat = 1;
    runCase(32'h0123_4FFF, 32'h0000_F001, 32'h0001_0001, 32'h0001_1001,
            32'h1234_56FE, "R11");
    runCase(32'h0123_4000, 32'h0000_F001, 32'h0001_0001, 32'h0001_1001,
            32'h8765_4303, "R1");
    while (expQ.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule